// File: doc/BRIEF.md
# GPIO Task/Event Channel

This block ties one selectable pad of a GPIO bank either to output tasks or to input edge events. A configuration word, written with a single-cycle write strobe, picks the operating mode, the pad (pin and port select), the polarity and an initial output level. In task mode, three task strobes change the level driven onto the selected pad: toggle-by-polarity, force-high and force-low. In event mode, the selected pad's input is synchronised, watched for the transition named by the polarity, and each matching transition yields a one-cycle event pulse.

The block drives a per-pad output value and output-enable vector toward the pad multiplexer. At most one enable bit is set, and only in task mode. Every write of the configuration word re-initialises the channel's tracked level, so reconfiguration never yields a stale level or a spurious event. There is no data stream here: all ports are plain control and status signals, so no valid/ready handshake applies.

Top module: `gpio_te_chan`

## Requirements
- R1: After reset, the mode is disabled: `pad_oe` and `pad_out` are all zero and `evt_pulse` is low.
- R2: In task mode, `pad_oe` has exactly one bit set: the bit at index {port, pin} of the current selection. `pad_out` carries the driven level on that bit only and is zero elsewhere. With the default widths, config bits [1:0] are the mode (0 disabled, 1 event, 2 task, 3 reserved and treated as disabled), [6:2] the pin, [7] the port, [9:8] the polarity and [10] the initial level.
- R3: A configuration write that selects task mode loads the driven level from the initial-level bit. The level shows on `pad_out` from the cycle after the write.
- R4: An OUT strobe in task mode acts by polarity (0 none, 1 low-to-high, 2 high-to-low, 3 toggle). None leaves the level unchanged, low-to-high drives it high, high-to-low drives it low, and toggle inverts it.
- R5: A SET strobe in task mode drives the level high and a CLR strobe drives it low, whatever the polarity.
- R6: Strobes in the same cycle resolve with CLR first, then SET, then OUT. A configuration write in the same cycle as strobes takes precedence over all of them.
- R7: Task strobes outside task mode change no output: `pad_oe`, `pad_out` and `evt_pulse` stay zero.
- R8: In event mode, a change on the selected pad gives exactly one single-cycle `evt_pulse` when it matches the polarity. Low-to-high fires on a rising change, high-to-low on a falling change, toggle on any change, and none never fires. The pulse goes high at the third rising clock edge after the pad settles.
- R9: A configuration write that selects event mode loads the tracked level from the current synchronised level of the newly selected pad, so the write itself causes no event.
- R10: Changing the pin/port selection moves the enable to the new pad at once. Leaving task mode clears `pad_oe` entirely.
- R11: Outside event mode, `evt_pulse` stays low whatever the pads do. Changes on unselected pads never cause events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | One-cycle configuration write strobe |
| cfg_wdata | input | CFG_W (11) | Configuration word |
| tsk_out | input | 1 | Polarity-driven output task strobe |
| tsk_set | input | 1 | Force-high task strobe |
| tsk_clr | input | 1 | Force-low task strobe |
| pad_in | input | NPAD (64) | Asynchronous pad input levels |
| pad_out | output | NPAD (64) | Output value toward the pad multiplexer |
| pad_oe | output | NPAD (64) | Output enable toward the pad multiplexer |
| evt_pulse | output | 1 | Single-cycle event pulse |

## Verification
The assertions assume no constraint on `pad_in` or on the strobes: strobes may coincide with each other and with a configuration write. They do assume reset is held for at least one clock edge before any property is evaluated. The stimulus lets pad changes settle through the synchroniser before it issues a configuration write or a check, so the level loaded at an event-mode write is the one the bench expects. It also waits several cycles after every pad change, so each expected pulse falls inside the counting window.

// File: rtl/gte_pkg.sv
package gte_pkg;

  typedef enum logic [1:0] {
    MD_OFF  = 2'd0,
    MD_EVT  = 2'd1,
    MD_TASK = 2'd2,
    MD_RSV  = 2'd3
  } gte_mode_e;

  typedef enum logic [1:0] {
    PL_NONE = 2'd0,
    PL_RISE = 2'd1,
    PL_FALL = 2'd2,
    PL_TOGL = 2'd3
  } gte_pol_e;

  function automatic logic edge_match(gte_pol_e pol, logic prev, logic curr);
    case (pol)
      PL_RISE: return !prev && curr;
      PL_FALL: return prev && !curr;
      PL_TOGL: return prev != curr;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gte_cfg_reg.sv
module gte_cfg_reg
  import gte_pkg::*;
#(
  parameter int PIN_W  = 5,
  parameter int PORT_W = 1,
  localparam int SEL_W = PIN_W + PORT_W,
  localparam int CFG_W = SEL_W + 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output gte_mode_e        mode_w,
  output logic [SEL_W-1:0] sel_w,
  output logic             init_w,
  output gte_mode_e        mode_q,
  output logic [SEL_W-1:0] sel_q,
  output gte_pol_e         pol_q
);

  localparam int SEL_LO = 2;
  localparam int POL_LO = SEL_LO + SEL_W;
  localparam int INI_B  = POL_LO + 2;

  assign mode_w = gte_mode_e'(wdata[1:0]);
  assign sel_w  = wdata[SEL_LO +: SEL_W];
  assign init_w = wdata[INI_B];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MD_OFF;
      sel_q  <= '0;
      pol_q  <= PL_NONE;
    end else if (we) begin
      mode_q <= mode_w;
      sel_q  <= sel_w;
      pol_q  <= gte_pol_e'(wdata[POL_LO +: 2]);
    end
  end

endmodule

// File: rtl/gte_sync.sv
module gte_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= din[i];
        s2 <= s1;
      end
    end
    assign dout[i] = s2;
  end

endmodule

// File: rtl/gte_task_drv.sv
module gte_task_drv
  import gte_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_task,
  input  logic     load,
  input  logic     init,
  input  gte_pol_e pol,
  input  logic     st_out,
  input  logic     st_set,
  input  logic     st_clr,
  output logic     level
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= 1'b0;
    end else if (load) begin
      level <= init;
    end else if (in_task) begin
      if (st_clr)       level <= 1'b0;
      else if (st_set)  level <= 1'b1;
      else if (st_out) begin
        case (pol)
          PL_RISE: level <= 1'b1;
          PL_FALL: level <= 1'b0;
          PL_TOGL: level <= ~level;
          default: level <= level;
        endcase
      end
    end
  end

  // R6
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_task && !load && st_clr) |=> !level);
  // R5
  set_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_task && !load && st_set && !st_clr) |=> level);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_task && !load) |=> $stable(level));
  // R3
  init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (level == $past(init)));

endmodule

// File: rtl/gte_edge_det.sv
module gte_edge_det
  import gte_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     active,
  input  logic     load,
  input  logic     load_val,
  input  logic     smp,
  input  gte_pol_e pol,
  output logic     evt
);

  logic trk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trk <= 1'b0;
      evt <= 1'b0;
    end else if (load) begin
      trk <= load_val;
      evt <= 1'b0;
    end else if (active) begin
      trk <= smp;
      evt <= edge_match(pol, trk, smp);
    end else begin
      evt <= 1'b0;
    end
  end

  // R9
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !evt);
  // R11
  evt_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> $past(active));

endmodule

// File: rtl/gpio_te_chan.sv
module gpio_te_chan
  import gte_pkg::*;
#(
  parameter int PIN_W  = 5,
  parameter int PORT_W = 1,
  localparam int SEL_W = PIN_W + PORT_W,
  localparam int NPAD  = 1 << SEL_W,
  localparam int CFG_W = SEL_W + 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             tsk_out,
  input  logic             tsk_set,
  input  logic             tsk_clr,
  input  logic [NPAD-1:0]  pad_in,
  output logic [NPAD-1:0]  pad_out,
  output logic [NPAD-1:0]  pad_oe,
  output logic             evt_pulse
);

  gte_mode_e        mode_w, mode_q;
  gte_pol_e         pol_q;
  logic [SEL_W-1:0] sel_w, sel_q;
  logic             init_w;
  logic [NPAD-1:0]  pad_s;
  logic             level;
  logic             in_task;

  gte_cfg_reg #(.PIN_W(PIN_W), .PORT_W(PORT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .mode_w(mode_w), .sel_w(sel_w), .init_w(init_w),
    .mode_q(mode_q), .sel_q(sel_q), .pol_q(pol_q)
  );

  gte_sync #(.W(NPAD)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pad_s)
  );

  assign in_task = (mode_q == MD_TASK);

  gte_task_drv u_drv (
    .clk(clk), .rst_n(rst_n), .in_task(in_task),
    .load(cfg_we && mode_w == MD_TASK), .init(init_w), .pol(pol_q),
    .st_out(tsk_out), .st_set(tsk_set), .st_clr(tsk_clr), .level(level)
  );

  gte_edge_det u_det (
    .clk(clk), .rst_n(rst_n),
    .active(mode_q == MD_EVT && !cfg_we),
    .load(cfg_we && mode_w == MD_EVT), .load_val(pad_s[sel_w]),
    .smp(pad_s[sel_q]), .pol(pol_q), .evt(evt_pulse)
  );

  for (genvar i = 0; i < NPAD; i++) begin : g_pad
    assign pad_oe[i]  = in_task && (sel_q == SEL_W'(i));
    assign pad_out[i] = pad_oe[i] && level;
  end

  // R2
  oe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pad_oe));
  // R2
  out_in_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);
  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MD_TASK) |-> (pad_oe == '0));
  // R11
  evt_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> (pad_oe == '0));

endmodule

// File: tb/gpio_te_chan_test.sv
module gpio_te_chan_test;

  localparam int PIN_W = 5;
  localparam int PORT_W = 1;
  localparam int SEL_W = PIN_W + PORT_W;
  localparam int NPAD = 1 << SEL_W;
  localparam int CFG_W = SEL_W + 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic tsk_out = 1'b0, tsk_set = 1'b0, tsk_clr = 1'b0;
  logic [NPAD-1:0] pad_in = '0;
  logic [NPAD-1:0] pad_out, pad_oe;
  logic evt_pulse;

  int checks = 0, errors = 0, evt_cnt = 0;
  int m_mode = 0, m_pol = 0, m_sel = 0, m_evt = 0;
  logic m_lvl = 1'b0;

  always #5 clk = ~clk;

  gpio_te_chan #(.PIN_W(PIN_W), .PORT_W(PORT_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tsk_out(tsk_out), .tsk_set(tsk_set), .tsk_clr(tsk_clr),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .evt_pulse(evt_pulse)
  );

  always @(negedge clk) if (rst_n && evt_pulse) evt_cnt++;

  function automatic logic [CFG_W-1:0] cfg_word(int mode, int sel, int pol, logic init);
    return {init, 2'(pol), SEL_W'(sel), 2'(mode)};
  endfunction

  function automatic logic fire(int pol, logic o, logic n);
    case (pol)
      1: return !o && n;
      2: return o && !n;
      3: return o != n;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic task_next(int pol, logic lvl, logic o, logic s, logic c);
    if (c) return 1'b0;
    if (s) return 1'b1;
    if (o) begin
      case (pol)
        1: return 1'b1;
        2: return 1'b0;
        3: return !lvl;
        default: return lvl;
      endcase
    end
    return lvl;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_model(string req);
    logic [63:0] eoe, eout;
    eoe  = (m_mode == 2) ? (64'd1 << m_sel) : 64'd0;
    eout = (m_mode == 2 && m_lvl) ? (64'd1 << m_sel) : 64'd0;
    check({req, " oe"}, 64'(pad_oe), eoe);
    check({req, " out"}, 64'(pad_out), eout);
    check({req, " evt"}, 64'(evt_cnt), 64'(m_evt));
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_cfg(int mode, int sel, int pol, logic init);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = cfg_word(mode, sel, pol, init);
    @(negedge clk);
    cfg_we = 1'b0;
    m_mode = (mode == 3) ? 0 : mode;
    m_sel = sel;
    m_pol = pol;
    if (mode == 2) m_lvl = init;
    settle();
  endtask

  task automatic do_tasks(logic o, logic s, logic c);
    @(negedge clk);
    tsk_out = o; tsk_set = s; tsk_clr = c;
    @(negedge clk);
    tsk_out = 1'b0; tsk_set = 1'b0; tsk_clr = 1'b0;
    if (m_mode == 2) m_lvl = task_next(m_pol, m_lvl, o, s, c);
    settle();
  endtask

  task automatic do_pad(int idx, logic v);
    @(negedge clk);
    if (m_mode == 1 && idx == m_sel) m_evt += int'(fire(m_pol, pad_in[idx], v));
    pad_in[idx] = v;
    settle();
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_model("R1");

    // R2 R3 task mode on pad 3 with initial level high
    do_cfg(2, 3, 3, 1'b1);
    check_model("R2 R3");
    // R4 toggle
    do_tasks(1, 0, 0);
    check_model("R4 toggle");
    // R6 all three together: CLR wins
    do_tasks(1, 1, 0);
    check_model("R6 set over out");
    do_tasks(1, 1, 1);
    check_model("R6 clr over all");
    // R4 polarity none leaves level
    do_cfg(2, 3, 0, 1'b1);
    do_tasks(1, 0, 0);
    check_model("R4 none");
    // R5 CLR/SET regardless of polarity
    do_tasks(0, 0, 1);
    check_model("R5 clr");
    do_tasks(0, 1, 0);
    check_model("R5 set");
    // R6 config write wins over same-cycle strobe
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = cfg_word(2, 3, 1, 1'b0); tsk_set = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; tsk_set = 1'b0;
    m_pol = 1; m_lvl = 1'b0;
    settle();
    check_model("R6 cfg over strobe");
    // R10 reselect moves enable
    do_cfg(2, 40, 1, 1'b1);
    check_model("R10 reselect");
    // R7 R10 disabled: strobes do nothing, pad released
    do_cfg(0, 40, 3, 1'b1);
    do_tasks(1, 1, 0);
    check_model("R7 R10 disabled");
    // R9 event config on a high pad gives no event
    do_pad(5, 1'b1);
    do_cfg(1, 5, 3, 1'b0);
    check_model("R9 no cfg event");
    // R8 falling on toggle polarity, R11 unselected pad ignored
    do_pad(5, 1'b0);
    check_model("R8 toggle fall");
    do_pad(6, 1'b1);
    check_model("R11 unselected");
    do_tasks(1, 1, 1);
    check_model("R7 event mode strobes");
    // R8 rise-only polarity
    do_cfg(1, 5, 1, 1'b0);
    do_pad(5, 1'b1);
    do_pad(5, 1'b0);
    check_model("R8 rise only");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom % 4;
      if (op == 0) begin
        int sel;
        sel = ($urandom % 2) ? m_sel : int'($urandom % NPAD);
        do_cfg($urandom % 4, sel, $urandom % 4, 1'($urandom));
        check_model("R3 R9 R10 random cfg");
      end else if (op == 1) begin
        do_tasks(1'($urandom), 1'($urandom), 1'($urandom));
        check_model("R4 R5 R6 R7 random task");
      end else begin
        int idx;
        idx = ($urandom % 4 != 0) ? m_sel : int'($urandom % NPAD);
        do_pad(idx, ~pad_in[idx]);
        check_model("R8 R11 random pad");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule